// File: doc/BRIEF.md
# Flow-Controlled Register Slice with Link Traffic Counters

This block is one register slice for a streaming datapath whose links use a strobe/acknowledge handshake. The sender raises a strobe with a payload word. The receiver raises an acknowledge whenever it can take a word. A word moves in every cycle where both are high. The slice holds at most one word and passes the payload through unchanged. Its upstream acknowledge comes only from its own occupancy and from the downstream acknowledge, never from the upstream strobe. A long chain of slices therefore never forms a strobe-to-acknowledge combinational loop.

A monitor watches the upstream link and keeps two free-running counters. One counts the cycles in which the link is blocked: a word is offered and not taken. The other counts the cycles in which a word is taken. Software or a sequencer pulses the clear input when a new frame begins. The counters can then be read once the frame has finished, to show where a pipeline loses throughput.

Top module: `pipe_stage_mon`

## Requirements
- R1: In the first cycle after synchronous reset, the slice is empty: `dn_stb` is 0 and `up_ack` is 1. Both counters are 0.
- R2: While the slice is empty, `up_ack` is 1 whatever `up_stb` and `dn_ack` are doing.
- R3: While the slice is full, `up_ack` equals `dn_ack` in the same cycle. The value of `up_stb` never changes `up_ack`.
- R4: A word taken upstream (`up_stb`=1 and `up_ack`=1 at a clock edge) appears on `dn_data` with `dn_stb`=1 in the next cycle.
- R5: While `dn_stb` is 1 and `dn_ack` is 0, `dn_stb` stays 1 and `dn_data` holds its value at the next edge.
- R6: Words leave in the order they entered. Each word leaves exactly once, with no loss and no duplication.
- R7: Each clock edge with `up_stb`=1, `up_ack`=0 and `cnt_clr`=0 raises `stall_cnt` by exactly one.
- R8: Each clock edge with `up_stb`=1, `up_ack`=1 and `cnt_clr`=0 raises `done_cnt` by exactly one.
- R9: An edge with `cnt_clr`=1 sets both counters to 0, even when a stall or a transfer happens in the same cycle. That event is not counted.
- R10: Both counters wrap from all ones to zero modulo 2^CNT_W. CNT_W is 32 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_clr | input | 1 | Clears both traffic counters at the next edge (frame start) |
| up_stb | input | 1 | Upstream sender offers a word |
| up_ack | output | 1 | Slice can accept a word this cycle |
| up_data | input | W | Upstream payload |
| dn_stb | output | 1 | Slice offers its held word downstream |
| dn_ack | input | 1 | Downstream receiver can accept a word |
| dn_data | output | W | Held payload |
| stall_cnt | output | CNT_W | Blocked-cycle count on the upstream link |
| done_cnt | output | CNT_W | Completed-transfer count on the upstream link |

## Verification
Two things can happen on the same edge. A counter clear can coincide with a counted link event, and a word can enter the slice in the same cycle that the held word leaves. The bench drives a clear pulse while a blocked or completing offer is present, and expects zero in both counters on the following cycle rather than one. It holds the slice full with `dn_ack` high while a new offer arrives. It then expects the old word to leave, the new word to be held, and the sequence numbers of the random traffic to come out consecutively.

// File: rtl/pipe_mon_pkg.sv
package pipe_mon_pkg;

    // Classification of one cycle on a strobe/acknowledge link
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_STALL = 2'd1,
        EV_DONE  = 2'd2
    } link_ev_e;

    localparam int NUM_CNT = 2;

    function automatic link_ev_e classify(input logic stb, input logic ack);
        if (!stb)
            return EV_IDLE;
        else if (ack)
            return EV_DONE;
        else
            return EV_STALL;
    endfunction

    // Counter slot g watches this event kind
    function automatic link_ev_e slot_event(input int g);
        return (g == 0) ? EV_STALL : EV_DONE;
    endfunction

endpackage

// File: rtl/stage_hold.sv
module stage_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_stb,
    output logic         up_ack,
    input  logic [W-1:0] up_data,
    output logic         dn_stb,
    input  logic         dn_ack,
    output logic [W-1:0] dn_data
);

    logic         full_q;
    logic [W-1:0] word_q;
    logic         take;

    // Acceptance depends on occupancy and the downstream side only
    assign up_ack = !full_q || dn_ack;
    assign take   = up_stb && up_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (take) begin
            full_q <= 1'b1;
        end else if (dn_ack) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (take)
            word_q <= up_data;
    end

    assign dn_stb  = full_q;
    assign dn_data = word_q;

endmodule

// File: rtl/link_watch.sv
module link_watch
    import pipe_mon_pkg::*;
(
    input  logic     stb,
    input  logic     ack,
    output link_ev_e ev
);

    assign ev = classify(stb, ack);

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + ONE;   // wraps naturally
    end

endmodule

// File: rtl/pipe_stage_mon.sv
module pipe_stage_mon
    import pipe_mon_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_clr,
    input  logic             up_stb,
    output logic             up_ack,
    input  logic [W-1:0]     up_data,
    output logic             dn_stb,
    input  logic             dn_ack,
    output logic [W-1:0]     dn_data,
    output logic [CNT_W-1:0] stall_cnt,
    output logic [CNT_W-1:0] done_cnt
);

    link_ev_e         ev;
    logic [CNT_W-1:0] cnt_arr [NUM_CNT];

    stage_hold #(.W(W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .up_stb  (up_stb),
        .up_ack  (up_ack),
        .up_data (up_data),
        .dn_stb  (dn_stb),
        .dn_ack  (dn_ack),
        .dn_data (dn_data)
    );

    link_watch u_watch (
        .stb (up_stb),
        .ack (up_ack),
        .ev  (ev)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        evt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (cnt_clr),
            .inc (ev == slot_event(g)),
            .cnt (cnt_arr[g])
        );
    end

    assign stall_cnt = cnt_arr[0];
    assign done_cnt  = cnt_arr[1];

endmodule

// File: rtl/pipe_mon_chk.sv
module pipe_mon_chk #(
    parameter int W     = 16,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_clr,
    input logic             up_stb,
    input logic             up_ack,
    input logic [W-1:0]     up_data,
    input logic             dn_stb,
    input logic             dn_ack,
    input logic [W-1:0]     dn_data,
    input logic [CNT_W-1:0] stall_cnt,
    input logic [CNT_W-1:0] done_cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        !dn_stb |-> up_ack);                                               // R2

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (dn_stb && !dn_ack) |-> !up_ack);                                  // R3

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (up_stb && up_ack) |=> (dn_stb && dn_data == $past(up_data)));     // R4

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        (dn_stb && !dn_ack) |=> (dn_stb && $stable(dn_data)));             // R5

    AST_STALL_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && up_stb && !up_ack) |=> (stall_cnt == $past(stall_cnt) + ONE)); // R7

    AST_DONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && up_stb && up_ack) |=> (done_cnt == $past(done_cnt) + ONE));    // R8

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (stall_cnt == '0 && done_cnt == '0));                 // R9

endmodule

bind pipe_stage_mon pipe_mon_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_clr   (cnt_clr),
    .up_stb    (up_stb),
    .up_ack    (up_ack),
    .up_data   (up_data),
    .dn_stb    (dn_stb),
    .dn_ack    (dn_ack),
    .dn_data   (dn_data),
    .stall_cnt (stall_cnt),
    .done_cnt  (done_cnt)
);

// File: tb/sim_pipe_stage_mon.sv
`timescale 1ns/1ps
module sim_pipe_stage_mon;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_clr = 1'b0;
    logic         up_stb = 1'b0;
    logic [W-1:0] up_data = '0;
    logic         dn_ack = 1'b0;
    logic         up_ack, dn_stb, up_ack1, dn_stb1;
    logic [W-1:0] dn_data, dn_data1;
    logic [31:0]  stall_cnt, done_cnt;
    logic [3:0]   stall_n4, done_n4;

    always #10 clk = ~clk;   // 50 MHz

    pipe_stage_mon #(.W(W), .CNT_W(32)) u0 (
        .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .up_stb(up_stb), .up_ack(up_ack),
        .up_data(up_data), .dn_stb(dn_stb), .dn_ack(dn_ack), .dn_data(dn_data),
        .stall_cnt(stall_cnt), .done_cnt(done_cnt));

    // Narrow-counter copy for the wrap check (R10)
    pipe_stage_mon #(.W(W), .CNT_W(4)) u1 (
        .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .up_stb(up_stb), .up_ack(up_ack1),
        .up_data(up_data), .dn_stb(dn_stb1), .dn_ack(dn_ack), .dn_data(dn_data1),
        .stall_cnt(stall_n4), .done_cnt(done_n4));

    int unsigned vectors = 0;
    int unsigned errors  = 0;

    // Reference model state
    logic         m_full = 1'b0;
    logic [W-1:0] m_data = '0;
    logic [31:0]  m_stall = '0, m_done = '0;
    logic         last_ack;
    logic         seq_mode = 1'b0;
    logic [W-1:0] rx_seq = '0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_ack(input logic full, input logic da);
        return !full || da;
    endfunction

    task automatic step(input logic s, input logic [W-1:0] d, input logic da, input logic c);
        @(negedge clk);
        up_stb = s; up_data = d; dn_ack = da; cnt_clr = c;
        #1;
        last_ack = exp_ack(m_full, da);
        if (!m_full) check("R2 ack when empty", 64'(up_ack), 64'(1'b1));
        else         check("R3 ack follows dn_ack", 64'(up_ack), 64'(last_ack));
        // flip the offer: acknowledge must not move (R3)
        up_stb = !s; #1;
        check("R3 ack independent of stb", 64'(up_ack), 64'(last_ack));
        up_stb = s; #1;
        check("R5 dn_stb", 64'(dn_stb), 64'(m_full));
        if (m_full) check("R4 R5 dn_data", 64'(dn_data), 64'(m_data));
        check("R7 stall_cnt", 64'(stall_cnt), 64'(m_stall));
        check("R8 done_cnt", 64'(done_cnt), 64'(m_done));
        check("R10 narrow stall wrap", 64'(stall_n4), 64'(m_stall[3:0]));
        check("R10 narrow done wrap", 64'(done_n4), 64'(m_done[3:0]));
        if (seq_mode && m_full && da) begin
            check("R6 order", 64'(dn_data), 64'(rx_seq));
            rx_seq++;
        end
        // model update at the coming edge
        if (c) begin
            m_stall = '0; m_done = '0;      // R9: clear wins
        end else if (s) begin
            if (last_ack) m_done++; else m_stall++;
        end
        if (s && last_ack) begin
            m_full = 1'b1; m_data = d;
        end else if (da) begin
            m_full = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic         pend;
        logic [W-1:0] tx_seq;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 up_ack", 64'(up_ack), 64'(1'b1));
        check("R1 dn_stb", 64'(dn_stb), 64'(1'b0));
        check("R1 stall_cnt", 64'(stall_cnt), 64'(0));
        check("R1 done_cnt", 64'(done_cnt), 64'(0));

        // Directed: fill, then block for three cycles (R3, R5, R7)
        step(1'b1, 16'hA001, 1'b0, 1'b0);
        step(1'b1, 16'hB002, 1'b0, 1'b0);
        step(1'b1, 16'hB002, 1'b0, 1'b0);
        step(1'b1, 16'hB002, 1'b0, 1'b0);
        // pass-through while full: old leaves, new enters (R3, R4)
        step(1'b1, 16'hB002, 1'b1, 1'b0);
        step(1'b0, 16'h0000, 1'b0, 1'b0);
        // clear coinciding with a stall (R9)
        step(1'b1, 16'hC003, 1'b0, 1'b1);
        step(1'b1, 16'hC003, 1'b0, 1'b0);
        // clear coinciding with a completion (R9)
        step(1'b1, 16'hC003, 1'b1, 1'b1);
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        // empty slice, receiver idle: ack high (R2)
        step(1'b0, 16'h0000, 1'b0, 1'b0);
        step(1'b1, 16'hD004, 1'b0, 1'b0);
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        step(1'b0, 16'h0000, 1'b1, 1'b0);

        // Random traffic with sequence numbers (R6, R7, R8, R10)
        seq_mode = 1'b1;
        tx_seq = 16'h0100; rx_seq = 16'h0100;
        pend = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            logic da, c;
            if (!pend && ($urandom % 4 != 0)) pend = 1'b1;
            da = ((i / 64) % 2 == 0) ? ($urandom % 4 != 0) : ($urandom % 3 == 0);
            c  = ($urandom % 97 == 0);
            step(pend, pend ? tx_seq : 16'h0, da, c);
            if (pend && last_ack) begin
                pend = 1'b0;
                tx_seq++;
            end
        end
        // drain
        for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 1'b1, 1'b0);
        check("R6 all words delivered", 64'(rx_seq), 64'(tx_seq));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule